// File: doc/BRIEF.md
# Blanking-Aligned Comparator Sense Sampler

This block turns a noisy one-bit comparator output into two trustworthy readings. Each reading is taken just after a horizontal blanking interval ends. A load-detection routine uses it to decide whether an analog display output has a termination attached. The routine sets up the output, pulses `start_i`, and waits for `done_o`. The two readings then appear on `result_o`. If blanking stops toggling, `timeout_o` is set instead.

Each reading has two phases. First, the sequencer tracks the blanking level through three phases: active video, then blanking, then active video again. Each phase is guarded by its own timeout. Second, after a settle delay, the sampler captures a reference value and then takes a comparison sample at a fixed period until a sample agrees with the reference. If a disagreeing sample is immediately confirmed by the next cycle's sample, that value replaces the reference, and comparison continues. If agreement never comes within a bounded number of mismatches, the reading is forced to 0. A low comparator level means the comparator has tripped.

All delays are parameters counted in clock cycles. An optional synchronizer on the two asynchronous inputs is selected by parameter.

Top module: `hblank_sense_probe`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `timeout_o` are 0 and `result_o` is 2'b00.
- R2: A `start_i` seen while idle makes `busy_o` 1 from the next cycle. It also clears `timeout_o` and `result_o`.
- R3: For each reading, the block waits for blanking low, then blanking high, then blanking low. Comparator values present before that last low level is seen have no effect on the reading.
- R4: Each of the three waits aborts the request after `TIMEOUT_CYC` cycles without its condition. On abort, `done_o` pulses, `timeout_o` becomes 1 and stays 1 until the next accepted start, `result_o` stays 2'b00, and `busy_o` drops.
- R5: The reference is captured `SETTLE_CYC` cycles after the blanking exit is seen. Comparison samples follow every `SAMPLE_CYC` cycles, and a sample equal to the reference ends the reading with the reference value.
- R6: A comparison sample that differs from the reference and is matched by the sample one cycle later becomes the new reference. The reading then continues with the next comparison sample.
- R7: A differing comparison sample whose next-cycle sample does not match it leaves the reference unchanged.
- R8: When `MAX_OSC` comparison samples in one reading have differed from the reference, the reading ends with the value 0. With `MAX_OSC`-1 mismatches followed by agreement, the reference value is kept.
- R9: `result_o[0]` holds the first reading and `result_o[1]` the second. On completion `done_o` is high for exactly one cycle, `busy_o` is 0 in that cycle, and `timeout_o` is 0.
- R10: A `start_i` while busy has no effect: the request in progress finishes with its own result and a single `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, accepted only when idle |
| hblank_i | input | 1 | Horizontal blanking level, high during blanking |
| sense_i | input | 1 | Raw comparator output, low when tripped |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse at completion or abort |
| timeout_o | output | 1 | Last request aborted on a blanking wait |
| result_o | output | 2 | Reading 1 in bit 1, reading 0 in bit 0 |

## Verification
The checker assumes `start_i` is synchronous to `clk`. It also assumes that only `start_i` raises `busy_o`, so any rise in busy can be traced to a start one cycle earlier. The bench drives every input on the falling edge. It changes the comparator bit only midway between the sample instants it derives from the blanking exit it produced. The only exception is single-cycle glitches placed deliberately at a confirmation instant. Blanking phases are kept several cycles long and well inside the timeout, except in the runs that deliberately stall one of the three waits.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

   typedef enum logic [2:0] {
      HBS_IDLE,
      HBS_SEEK_ACTIVE,
      HBS_SEEK_BLANK,
      HBS_SEEK_EXIT,
      HBS_SETTLE,
      HBS_GAP,
      HBS_CONFIRM
   } hbs_state_t;

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 0) begin : g_bad_stages
      $error("hbs_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [W-1:0] pipe_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
         end else begin
            pipe_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
         end
      end

      assign q_o = pipe_q[STAGES-1];
   end

endmodule

// File: rtl/hbs_interval.sv
module hbs_interval #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic [W-1:0] limit_i,
   output logic         hit_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else              cnt_q <= cnt_q + W'(1);
   end

   // The interval ends in the cycle where limit_i cycles have elapsed since clear
   assign hit_o = (cnt_q == (limit_i - W'(1)));

endmodule

// File: rtl/hblank_sense_probe.sv
module hblank_sense_probe
   import hbs_pkg::*;
#(
   parameter int TIMEOUT_CYC = 1000000,
   parameter int SETTLE_CYC  = 10000,
   parameter int SAMPLE_CYC  = 10000,
   parameter int MAX_OSC     = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       hblank_i,
   input  logic       sense_i,
   output logic       busy_o,
   output logic       done_o,
   output logic       timeout_o,
   output logic [1:0] result_o
);

   localparam int LONG_A  = (TIMEOUT_CYC > SETTLE_CYC) ? TIMEOUT_CYC : SETTLE_CYC;
   localparam int LONGEST = (LONG_A > SAMPLE_CYC) ? LONG_A : SAMPLE_CYC;
   localparam int CNT_W   = $clog2(LONGEST + 1);
   localparam int OSC_W   = $clog2(MAX_OSC + 1);

   if (TIMEOUT_CYC < 1) begin : g_bad_timeout
      $error("hblank_sense_probe: TIMEOUT_CYC must be at least 1");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("hblank_sense_probe: SETTLE_CYC must be at least 1");
   end
   if (SAMPLE_CYC < 2) begin : g_bad_sample
      $error("hblank_sense_probe: SAMPLE_CYC must be at least 2");
   end
   if (MAX_OSC < 1) begin : g_bad_osc
      $error("hblank_sense_probe: MAX_OSC must be at least 1");
   end

   // ---------------- input conditioning ----------------
   logic [1:0] raw_in, synced;
   logic       hb, sn;

   assign raw_in = {hblank_i, sense_i};

   hbs_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (synced)
   );

   assign hb = synced[1];
   assign sn = synced[0];

   // ---------------- state ----------------
   hbs_state_t       st_q, st_nxt;
   logic             idx_q;
   logic             ref_q, cand_q, rd0_q;
   logic [OSC_W-1:0] osc_q;
   logic             done_q, tmo_q;
   logic [1:0]       res_q;

   logic             tmr_hit, tmr_clear;
   logic [CNT_W-1:0] tmr_limit;
   logic             abort, fin_rd, rd_val;

   always_comb begin
      unique case (st_q)
         HBS_SEEK_ACTIVE,
         HBS_SEEK_BLANK,
         HBS_SEEK_EXIT: tmr_limit = CNT_W'(TIMEOUT_CYC);
         HBS_SETTLE:    tmr_limit = CNT_W'(SETTLE_CYC);
         HBS_GAP:       tmr_limit = CNT_W'(SAMPLE_CYC);
         default:       tmr_limit = CNT_W'(1);
      endcase
   end

   hbs_interval #(.W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (tmr_clear),
      .limit_i (tmr_limit),
      .hit_o   (tmr_hit)
   );

   // ---------------- sequencing ----------------
   always_comb begin
      st_nxt = st_q;
      abort  = 1'b0;
      fin_rd = 1'b0;
      rd_val = ref_q;
      unique case (st_q)
         HBS_IDLE: begin
            if (start_i) st_nxt = HBS_SEEK_ACTIVE;
         end
         HBS_SEEK_ACTIVE: begin
            if (!hb)          st_nxt = HBS_SEEK_BLANK;
            else if (tmr_hit) abort  = 1'b1;
         end
         HBS_SEEK_BLANK: begin
            if (hb)           st_nxt = HBS_SEEK_EXIT;
            else if (tmr_hit) abort  = 1'b1;
         end
         HBS_SEEK_EXIT: begin
            if (!hb)          st_nxt = HBS_SETTLE;
            else if (tmr_hit) abort  = 1'b1;
         end
         HBS_SETTLE: begin
            if (tmr_hit) st_nxt = HBS_GAP;
         end
         HBS_GAP: begin
            if (tmr_hit) begin
               if (sn == ref_q) begin
                  fin_rd = 1'b1;
                  rd_val = ref_q;
               end else begin
                  st_nxt = HBS_CONFIRM;
               end
            end
         end
         HBS_CONFIRM: begin
            if (osc_q == OSC_W'(MAX_OSC - 1)) begin
               fin_rd = 1'b1;
               rd_val = 1'b0;
            end else begin
               st_nxt = HBS_GAP;
            end
         end
         default: st_nxt = HBS_IDLE;
      endcase
      if (abort)  st_nxt = HBS_IDLE;
      if (fin_rd) st_nxt = idx_q ? HBS_IDLE : HBS_SEEK_ACTIVE;
   end

   // The confirm cycle keeps the interval running so comparison samples stay on a fixed grid
   assign tmr_clear = (st_nxt != st_q) && !((st_q == HBS_CONFIRM) && (st_nxt == HBS_GAP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= HBS_IDLE;
         idx_q  <= 1'b0;
         ref_q  <= 1'b0;
         cand_q <= 1'b0;
         rd0_q  <= 1'b0;
         osc_q  <= '0;
         done_q <= 1'b0;
         tmo_q  <= 1'b0;
         res_q  <= 2'b00;
      end else begin
         st_q   <= st_nxt;
         done_q <= 1'b0;
         if ((st_q == HBS_IDLE) && start_i) begin
            tmo_q <= 1'b0;
            res_q <= 2'b00;
            idx_q <= 1'b0;
         end
         if (abort) begin
            tmo_q  <= 1'b1;
            done_q <= 1'b1;
         end
         if ((st_q == HBS_SETTLE) && tmr_hit) begin
            ref_q <= sn;
            osc_q <= '0;
         end
         if ((st_q == HBS_GAP) && tmr_hit) cand_q <= sn;
         if (st_q == HBS_CONFIRM) begin
            if (sn == cand_q) ref_q <= cand_q;
            osc_q <= osc_q + OSC_W'(1);
         end
         if (fin_rd) begin
            if (!idx_q) begin
               rd0_q <= rd_val;
               idx_q <= 1'b1;
            end else begin
               res_q  <= {rd_val, rd0_q};
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy_o    = (st_q != HBS_IDLE);
   assign done_o    = done_q;
   assign timeout_o = tmo_q;
   assign result_o  = res_q;

endmodule

// File: rtl/hbs_probe_chk.sv
module hbs_probe_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       busy_o,
   input logic       done_o,
   input logic       timeout_o,
   input logic [1:0] result_o
);

   // R2
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   // R4
   tmo_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_o) |-> done_o);

   // R4
   abort_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && timeout_o) |-> (result_o == 2'b00));

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(result_o));

endmodule

bind hblank_sense_probe hbs_probe_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .timeout_o (timeout_o),
   .result_o  (result_o)
);

// File: tb/sim_hblank_sense_probe.sv
`timescale 1ns/1ps
module sim_hblank_sense_probe;

   localparam int TMO  = 300;
   localparam int STL  = 6;
   localparam int PER  = 8;
   localparam int MOSC = 20;
   localparam int LEN  = STL + PER * (MOSC + 1) + 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       hblank_i = 1'b0;
   logic       sense_i = 1'b0;
   logic       busy_o, done_o, timeout_o;
   logic [1:0] result_o;

   int tests = 0;
   int fails = 0;
   int done_cnt = 0;
   int pulse_err = 0;
   logic       prev_done = 1'b0;
   logic [1:0] res_seen = 2'b00;
   logic       tmo_seen = 1'b0;
   logic       busy_seen = 1'b0;

   always #2 clk = ~clk;

   hblank_sense_probe #(
      .TIMEOUT_CYC (TMO),
      .SETTLE_CYC  (STL),
      .SAMPLE_CYC  (PER),
      .MAX_OSC     (MOSC),
      .SYNC_STAGES (2)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .hblank_i  (hblank_i),
      .sense_i   (sense_i),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .timeout_o (timeout_o),
      .result_o  (result_o)
   );

   // passive monitor of completion events
   always @(negedge clk) begin
      if (rst_n) begin
         if (done_o) begin
            done_cnt  = done_cnt + 1;
            res_seen  = result_o;
            tmo_seen  = timeout_o;
            busy_seen = busy_o;
            if (prev_done) pulse_err = pulse_err + 1;
         end
         prev_done = done_o;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic exp_reading(input logic [31:0] v, input int g);
      logic r, b, bp;
      int   j;
      r = v[0];
      j = 0;
      for (int k = 1; k <= MOSC; k++) begin
         b = v[k];
         if (b == r) return r;
         bp = (k == g) ? ~b : b;
         if (bp == b) r = b;
         j++;
         if (j == MOSC) return 1'b0;
      end
      return 1'b0;
   endfunction

   function automatic logic sense_at(input logic [31:0] v, input int g, input int t);
      int k;
      if (g > 0 && t == STL + PER * g + 1) return ~v[g];
      if (t < STL - PER / 2) return v[0];
      k = (t - STL + PER / 2) / PER;
      if (k > 31) k = 31;
      return v[k];
   endfunction

   task automatic pulse_start();
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
      chk(timeout_o == 1'b0, "R2 timeout cleared", timeout_o, 0);
   endtask

   task automatic do_reading(input logic [31:0] v, input int g, input bit poke);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         hblank_i = 1'b0;
         sense_i  = 1'($urandom);
      end
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         hblank_i = 1'b1;
         sense_i  = 1'($urandom);
      end
      for (int t = 0; t <= LEN; t++) begin
         @(negedge clk);
         hblank_i = 1'b0;
         sense_i  = sense_at(v, g, t);
         start_i  = (poke && t == 20);
      end
      start_i = 1'b0;
   endtask

   task automatic run_pair(input logic [31:0] v0, input int g0,
                           input logic [31:0] v1, input int g1,
                           input bit poke, input string req);
      int   c0;
      logic e0, e1;
      c0 = done_cnt;
      e0 = exp_reading(v0, g0);
      e1 = exp_reading(v1, g1);
      pulse_start();
      do_reading(v0, g0, poke);
      do_reading(v1, g1, 1'b0);
      repeat (10) @(negedge clk);
      chk(done_cnt == c0 + 1, {req, " R9 single done"}, done_cnt - c0, 1);
      chk(res_seen == {e1, e0}, {req, " result"}, res_seen, {e1, e0});
      chk(tmo_seen == 1'b0 && busy_seen == 1'b0, "R9 flags at done",
          {tmo_seen, busy_seen}, 0);
   endtask

   task automatic run_timeout(input int mode, input int exp_m, input string req);
      int m;
      hblank_i = (mode == 0);
      repeat (6) @(negedge clk);
      start_i = 1'b1;
      m = 0;
      for (int i = 0; i < TMO + 40; i++) begin
         @(negedge clk);
         start_i = 1'b0;
         m++;
         if (mode == 2) begin
            if (m == 3) hblank_i = 1'b1;
            if (m == 7) hblank_i = 1'b0;
            if (m == 11) hblank_i = 1'b1;
         end
         if (done_o) break;
      end
      if (exp_m > 0) chk(m == exp_m, {req, " abort cycle"}, m, exp_m);
      else chk(done_o == 1'b1, {req, " abort seen"}, done_o, 1);
      chk(timeout_o == 1'b1 && result_o == 2'b00 && busy_o == 1'b0,
          {req, " abort flags"}, {timeout_o, busy_o, result_o}, 4'b1000);
      @(negedge clk);
      chk(done_o == 1'b0 && timeout_o == 1'b1, "R4 done drops, timeout held",
          {done_o, timeout_o}, 1);
      hblank_i = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] alt0, alt19;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      chk(busy_o == 0 && done_o == 0 && timeout_o == 0 && result_o == 0,
          "R1 reset state", {busy_o, done_o, timeout_o, result_o}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(busy_o == 0 && result_o == 0, "R1 idle after release",
          {busy_o, result_o}, 0);

      // R5 steady levels, R9 bit ordering
      run_pair(32'hFFFF_FFFF, -1, 32'h0000_0000, -1, 1'b0, "R5 R9 hi/lo");
      run_pair(32'h0000_0000, -1, 32'hFFFF_FFFF, -1, 1'b0, "R5 R9 lo/hi");
      // R6 confirmed change replaces the reference
      run_pair(32'h0000_0001, -1, 32'h0000_0006, -1, 1'b0, "R6 replace");
      // R7 unconfirmed change (glitch at confirm instant) keeps the reference
      run_pair(32'h0000_0006, 1, 32'h0000_0006, -1, 1'b0, "R7 glitch vs R6");
      // R8 oscillation limit forces 0, one short of it keeps the reference
      alt0  = 32'hAAAA_AAAA;
      alt19 = alt0 | 32'h0010_0000;
      run_pair(alt0, -1, alt19, -1, 1'b0, "R8 limit");
      run_pair(~alt0, -1, alt19, -1, 1'b0, "R8 limit from high");
      // R10 start while busy is ignored
      run_pair(32'hFFFF_FFFF, -1, 32'hFFFF_FFFE, -1, 1'b1, "R10 start while busy");

      // R4 timeouts on each of the three waits
      run_timeout(0, TMO + 1, "R4 first wait");
      run_timeout(1, TMO + 2, "R4 second wait");
      run_timeout(2, 0, "R4 third wait");
      // R3 random sense before blanking exit; R2 clears the timeout flag
      run_pair(32'h0000_0003, -1, 32'h0000_0003, 2, 1'b0, "R3 R2 after abort");

      for (int n = 0; n < 10; n++) begin
         logic [31:0] va, vb;
         int          ga, gb;
         va = $urandom;
         vb = $urandom;
         ga = int'($urandom_range(0, 6)) - 1;
         gb = int'($urandom_range(0, 6)) - 1;
         run_pair(va, ga, vb, gb, (n % 3) == 0, "R3 R5 R6 R7 random");
      end

      chk(pulse_err == 0, "R9 done width", pulse_err, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule